// File: doc/BRIEF.md
# Protected interrupt vector base selector

This block is a small control register placed next to a microcontroller core. It decides whether the interrupt vector table starts at word zero of program memory or at the first word of the boot-loader region. It also holds the enable bits for two external interrupt lines. Software reaches it through a one-cycle register write strobe and a read bus that always shows the current contents.

Moving the vector table is guarded. Software first sets the change-enable bit, which opens a short timed window. The vector-select bit then takes a new value only from a write that lands inside that window and clears change-enable in the same write. While the sequence is in progress the block raises a temporary interrupt mask for the interrupt arbiter. It has no connection to the core's global interrupt flag, so that flag is left alone.

The block also turns a 2-bit boot-size fuse code into the vector base word address. It combines two boot-lock inputs with the section the core is currently running from to add a lock-driven term to the same mask output. The asynchronous reset input passes through a two-stage synchronizer before the block uses it.

Top module: `ivec_ctrl`

## Requirements
- R1: Two cycles after reset is released, the read value is 0x00, ext_en is 0 and vec_base is 0. With both lock inputs low, irq_mask is 0.
- R2: Read layout: bit 7 is the external interrupt 1 enable and bit 6 the external interrupt 0 enable; any write loads both. Bits 5 down to 2 always read 0. Bit 1 is vector-select and bit 0 is change-enable. ext_en[1] mirrors bit 7 and ext_en[0] mirrors bit 6.
- R3: A write with bit 0 = 1 sets change-enable in the following cycle. With no further write, change-enable stays 1 for exactly 4 cycles and then clears by itself.
- R4: A write with bit 0 = 0 made while change-enable reads 1 loads bit 1 into vector-select. Change-enable reads 0 from the next cycle.
- R5: A write made while change-enable reads 0 leaves vector-select unchanged, whatever bit 1 holds.
- R6: A write with bit 0 = 1 made while the window is open leaves vector-select unchanged and restarts the 4-cycle count.
- R7: irq_mask is 1 in the cycle of an arming write, in every cycle in which change-enable reads 1, and in the one cycle after a qualifying vector-select write. If the window runs out unused, the timed part of the mask ends with the window.
- R8: vec_base is 0 when vector-select is 0. When vector-select is 1 it is 4096 − (256 << boot_size): codes 0, 1, 2 and 3 give 0xF00, 0xE00, 0xC00 and 0x800.
- R9: irq_mask is also 1 when vector-select is 1, lock_app_irq is 1 and exec_in_boot is 0. It is also 1 when vector-select is 0, lock_boot_irq is 1 and exec_in_boot is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| boot_size | input | 2 | Boot region size code (256 words << code) |
| exec_in_boot | input | 1 | Core is currently fetching from the boot region |
| lock_app_irq | input | 1 | Lock: block interrupts in the application region when vectors are in boot |
| lock_boot_irq | input | 1 | Lock: block interrupts in the boot region when vectors are in application |
| vec_base | output | 12 | Vector table base word address |
| ext_en | output | 2 | External interrupt enables {line 1, line 0} |
| irq_mask | output | 1 | Interrupts blocked this cycle |

## Verification
A fault in the window counter shows on the bit-0 read and on irq_mask within one to five cycles of an arming write. Closing the window early or late changes the cycle in which both fall. A wrong vector-select state appears at once on bit 1 of the read bus and on vec_base, and it also flips which lock input drives irq_mask. A lost post-write hold leaves irq_mask low in the one cycle after a qualifying write, so that cycle is compared on every sequence.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  // Bit positions decoded by software; they fix the register layout.
  localparam int unsigned CE_BIT  = 0;
  localparam int unsigned SEL_BIT = 1;
  localparam int unsigned EN0_BIT = 6;
  localparam int unsigned EN1_BIT = 7;
  localparam int unsigned REG_W   = 8;
endpackage

// File: rtl/ivec_unlock.sv
module ivec_unlock #(
  parameter int unsigned WINDOW = 4,
  parameter int unsigned TAIL   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_ce,
  input  logic wr_sel,
  output logic sel_q,
  output logic ce_q,
  output logic hold_q
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam int unsigned TW = $clog2(TAIL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tail_q, tail_d;
  logic          ce_d, sel_d;
  logic          arm, commit, win_en, tail_en;

  assign arm    = wr_en & wr_ce;
  assign commit = wr_en & ~wr_ce & ce_q;

  always_comb begin
    ce_d  = ce_q;
    cnt_d = cnt_q;
    if (arm) begin
      ce_d  = 1'b1;
      cnt_d = CW'(WINDOW);
    end else if (commit) begin
      ce_d  = 1'b0;
      cnt_d = '0;
    end else if (ce_q) begin
      if (cnt_q <= CW'(1)) begin
        ce_d  = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    sel_d  = commit ? wr_sel : sel_q;
    tail_d = commit ? TW'(TAIL) : (tail_q != '0 ? tail_q - TW'(1) : tail_q);
  end

  assign win_en  = arm | ce_q;
  assign tail_en = commit | (tail_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b0;
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (win_en) begin
      ce_q  <= ce_d;
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_en) tail_q <= tail_d;
  end

  assign hold_q = (tail_q != '0);
endmodule

// File: rtl/ivec_base.sv
module ivec_base #(
  parameter int unsigned MEM_WORDS = 4096,
  parameter int unsigned MIN_BOOT  = 256,
  parameter int unsigned CODE_W    = 2,
  localparam int unsigned AW       = $clog2(MEM_WORDS)
) (
  input  logic              sel,
  input  logic [CODE_W-1:0] code,
  output logic [AW-1:0]     base
);
  int unsigned boot_words;

  always_comb begin
    boot_words = MIN_BOOT << code;
    base       = sel ? AW'(MEM_WORDS - boot_words) : '0;
  end
endmodule

// File: rtl/ivec_lock.sv
module ivec_lock (
  input  logic sel,
  input  logic exec_in_boot,
  input  logic lock_app_irq,
  input  logic lock_boot_irq,
  output logic lock_mask
);
  always_comb begin
    lock_mask = (sel & lock_app_irq & ~exec_in_boot)
              | (~sel & lock_boot_irq & exec_in_boot);
  end
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl #(
  parameter int unsigned WINDOW    = 4,
  parameter int unsigned TAIL      = 1,
  parameter int unsigned MEM_WORDS = 4096,
  parameter int unsigned MIN_BOOT  = 256,
  parameter int unsigned CODE_W    = 2,
  localparam int unsigned AW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [CODE_W-1:0] boot_size,
  input  logic              exec_in_boot,
  input  logic              lock_app_irq,
  input  logic              lock_boot_irq,
  output logic [AW-1:0]     vec_base,
  output logic [1:0]        ext_en,
  output logic              irq_mask
);
  import ivec_pkg::*;

  logic [1:0] rsync;
  logic       rst_q;
  logic       wr_ok;
  logic [1:0] en_q;
  logic       sel_q, ce_q, hold_q, lock_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];
  assign wr_ok = wr_en & rst_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     en_q <= '0;
    else if (wr_ok) en_q <= {wr_data[EN1_BIT], wr_data[EN0_BIT]};
  end

  ivec_unlock #(.WINDOW(WINDOW), .TAIL(TAIL)) i_unlock (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (wr_ok),
    .wr_ce  (wr_data[CE_BIT]),
    .wr_sel (wr_data[SEL_BIT]),
    .sel_q  (sel_q),
    .ce_q   (ce_q),
    .hold_q (hold_q)
  );

  ivec_base #(.MEM_WORDS(MEM_WORDS), .MIN_BOOT(MIN_BOOT), .CODE_W(CODE_W)) i_base (
    .sel  (sel_q),
    .code (boot_size),
    .base (vec_base)
  );

  ivec_lock i_lock (
    .sel           (sel_q),
    .exec_in_boot  (exec_in_boot),
    .lock_app_irq  (lock_app_irq),
    .lock_boot_irq (lock_boot_irq),
    .lock_mask     (lock_mask)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[EN1_BIT] = en_q[1];
    rd_data[EN0_BIT] = en_q[0];
    rd_data[SEL_BIT] = sel_q;
    rd_data[CE_BIT]  = ce_q;
  end

  assign ext_en   = en_q;
  assign irq_mask = (wr_ok & wr_data[CE_BIT]) | ce_q | hold_q | lock_mask;
endmodule

// File: rtl/ivec_ctrl_chk.sv
module ivec_ctrl_chk #(
  parameter int unsigned WINDOW = 4,
  parameter int unsigned AW     = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [7:0]    rd_data,
  input logic [AW-1:0] vec_base,
  input logic          exec_in_boot,
  input logic          lock_app_irq,
  input logic          irq_mask
);
  localparam int unsigned RW = $clog2(WINDOW + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_q <= '0;
    else if (wr_en && wr_data[0])  run_q <= RW'(1);
    else if (rd_data[0])           run_q <= run_q + RW'(1);
    else                           run_q <= '0;
  end

  // R2
  ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:2] == 4'b0000);

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[7:6] == $past(wr_data[7:6]));

  // R3
  arm_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> rd_data[0]);

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> run_q <= RW'(WINDOW));

  // R4
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && rd_data[0]) |=> (rd_data[1] == $past(wr_data[1])) && !rd_data[0]);

  // R5
  sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] != $past(rd_data[1])) |-> $past(wr_en && rd_data[0] && !wr_data[0]));

  // R7
  mask_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> irq_mask);

  // R7
  mask_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && rd_data[0]) |=> irq_mask);

  // R8
  base_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> vec_base == '0);

  // R9
  lock_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && lock_app_irq && !exec_in_boot) |-> irq_mask);
endmodule

bind ivec_ctrl ivec_ctrl_chk #(.WINDOW(WINDOW), .AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_q),
  .wr_en        (wr_ok),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .vec_base     (vec_base),
  .exec_in_boot (exec_in_boot),
  .lock_app_irq (lock_app_irq),
  .irq_mask     (irq_mask)
);

// File: tb/test_ivec_ctrl.sv
`timescale 1ns/1ps
module test_ivec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [1:0]  boot_size;
  logic        exec_in_boot, lock_app_irq, lock_boot_irq;
  logic [11:0] vec_base;
  logic [1:0]  ext_en;
  logic        irq_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_sel = 0, m_ce = 0, m_left = 0, m_tail = 0, m_en = 0;

  always #2.5 clk = ~clk;

  ivec_ctrl i_ivec_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .boot_size(boot_size), .exec_in_boot(exec_in_boot), .lock_app_irq(lock_app_irq),
    .lock_boot_irq(lock_boot_irq), .vec_base(vec_base), .ext_en(ext_en), .irq_mask(irq_mask)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input string tag);
    int exp_rd, exp_base, exp_mask, lk;
    wr_en = w; wr_data = d;
    #1;
    exp_rd   = (m_en << 6) | (m_sel << 1) | m_ce;
    exp_base = m_sel ? 4096 - (256 << boot_size) : 0;
    lk = (m_sel && lock_app_irq && !exec_in_boot) || (!m_sel && lock_boot_irq && exec_in_boot);
    exp_mask = ((w && d[0]) || m_ce || m_tail > 0 || lk) ? 1 : 0;
    chk(tag, "rd_data", rd_data, exp_rd);
    chk(tag, "ext_en", ext_en, m_en);
    chk(tag, "vec_base", vec_base, exp_base);
    chk(tag, "irq_mask", irq_mask, exp_mask);
    @(posedge clk);
    if (w) m_en = d[7:6];
    if (w && !d[0] && m_ce) m_tail = 1;
    else if (m_tail > 0) m_tail--;
    if (w && d[0]) begin m_ce = 1; m_left = 4; end
    else if (w && m_ce) begin m_sel = d[1]; m_ce = 0; end
    else if (m_ce) begin
      if (m_left == 1) m_ce = 0;
      else m_left--;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, tag);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; boot_size = 2'd3;
    exec_in_boot = 1'b0; lock_app_irq = 1'b0; lock_boot_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R1");                        // reset state after synchronizer
    cyc(1'b1, 8'hC0, "R2");               // both external enables
    cyc(1'b1, 8'h7E, "R5");               // bit1 outside window, RO bits written
    idle(1, "R2");
    cyc(1'b1, 8'h01, "R3");               // arm, window runs out
    idle(6, "R3");                        // R7: mask ends with window
    cyc(1'b1, 8'h02, "R5");               // late write ignored
    idle(1, "R5");
    cyc(1'b1, 8'h41, "R3");               // arm
    idle(1, "R7");
    cyc(1'b1, 8'h42, "R4");               // qualifying write, sel=1
    idle(3, "R7");                        // post-write hold then release
    for (int c = 0; c < 4; c++) begin
      boot_size = c[1:0];
      idle(1, "R8");
    end
    boot_size = 2'd2;
    cyc(1'b1, 8'h01, "R6");               // arm
    idle(2, "R6");
    cyc(1'b1, 8'h01, "R6");               // re-arm, sel must hold at 1
    idle(3, "R6");                        // still open thanks to restart
    cyc(1'b1, 8'h80, "R4");               // sel=0
    idle(2, "R4");
    lock_boot_irq = 1'b1;
    exec_in_boot = 1'b1; idle(2, "R9");
    exec_in_boot = 1'b0; idle(2, "R9");
    lock_boot_irq = 1'b0; lock_app_irq = 1'b1;
    cyc(1'b1, 8'h01, "R9");
    cyc(1'b1, 8'h02, "R9");               // sel=1
    idle(2, "R9");
    exec_in_boot = 1'b1; idle(2, "R9");
    lock_app_irq = 1'b0; exec_in_boot = 1'b0;
    idle(2, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule